// File: doc/BRIEF.md
# Repeating Block Memory Copy Engine

This block is the sequencer behind the repeating, address-incrementing block copy instruction of an 8-bit processor. A start request loads a 16-bit source pointer, a 16-bit destination pointer, a 16-bit byte count, the accumulator value and the incoming flag byte. The engine then moves one byte per iteration over a simple memory bus. Each iteration has a read machine cycle and a write machine cycle. After each byte it updates the pointers, the count and the flags. It keeps going until the count reaches zero.

One clock is one T-state. The engine puts the kind of machine cycle it is in, and the T-state index within that cycle, on its ports, so a bus model or a trace can follow it. The flag byte keeps the processor's usual bit order, because the processor core reads it back: sign 7, zero 6, undocumented bit 5, half-carry 4, undocumented bit 3, parity/overflow 2, subtract 1, carry 0.

Top module: `blkcpy_top`

## Requirements
- R1: While reset is held and right after it, busy, done, the read strobe and the write strobe are 0, and the count, pointer and flag outputs read 0.
- R2: Each iteration opens with a read cycle of 3 T-states. In it, the read strobe is high, the address is the current source pointer, and the T-state index counts 0, 1, 2. The byte is taken from the read data on the last read T-state.
- R3: The read cycle is followed at once by a write cycle of 3 T-states. In it, the write strobe is high, the address is the current destination pointer, and the write data is the byte just read. Address and data stay stable through the write, and the two strobes are never high together.
- R4: After the write come 2 internal T-states with no strobe. At the end of them, the count is decremented and both pointers are incremented.
- R5: If the decremented count is not zero, parity/overflow (bit 2) is set, and 5 more internal T-states with no strobe follow before the next read. A repeating iteration therefore takes 13 clocks.
- R6: If the decremented count is zero, parity/overflow is cleared, busy drops with no extra T-states, and done is high for exactly one clock. The final iteration takes 8 clocks.
- R7: Half-carry (bit 4) and subtract (bit 1) are cleared on every iteration. Sign (bit 7), zero (bit 6) and carry (bit 0) keep the values loaded at start.
- R8: Flag bits 5 and 3 are bits 5 and 3 of the 8-bit sum of the accumulator and the byte just copied.
- R9: A count loaded as 0 wraps to 0xFFFF at its first decrement, so the engine keeps repeating (65536 transfers in all).
- R10: A start request that arrives while busy is ignored: the pointers, count and bus sequence of the running copy do not change.
- R11: Pointers wrap from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one T-state per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| src_init_i | input | 16 | Source pointer loaded at start |
| dst_init_i | input | 16 | Destination pointer loaded at start |
| cnt_init_i | input | 16 | Byte count loaded at start (0 means 65536) |
| acc_i | input | 8 | Accumulator value loaded at start |
| flags_i | input | 8 | Flag byte loaded at start |
| mem_rdata_i | input | 8 | Memory read data |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-clock pulse on completion |
| mcyc_o | output | 3 | Current machine-cycle kind (0 idle, 1 read, 2 write, 3 post-write internal, 4 repeat penalty) |
| tstate_o | output | 3 | T-state index within the current machine cycle |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| cnt_o | output | 16 | Current byte count |
| flags_o | output | 8 | Current flag byte |

## Verification
Some properties are checked on every cycle. These are the strobes never being high together, a write always following a read directly, address and data holding steady through a write, busy only ending with a done pulse that lasts one clock, half-carry, subtract and parity/overflow being clear at completion, and sign, zero and carry holding while the engine runs. Other behaviour can only be shown by the directed scenarios. That covers the exact T-state counts of the repeating and final iterations, the pointer and count values after each step, the undocumented bits taken from the accumulator sum, a start request ignored mid-copy, pointer wrap, and a count of zero wrapping into a long run.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RD   = 3'd1,
        PH_WR   = 3'd2,
        PH_GAP  = 3'd3,
        PH_REP  = 3'd4
    } phase_e;

    // flag byte bit positions, read back by the processor core
    localparam int FB_SIGN  = 7;
    localparam int FB_ZERO  = 6;
    localparam int FB_Y     = 5;
    localparam int FB_HALF  = 4;
    localparam int FB_X     = 3;
    localparam int FB_PV    = 2;
    localparam int FB_SUB   = 1;
    localparam int FB_CARRY = 0;
endpackage

// File: rtl/blkcpy_seq.sv
module blkcpy_seq
    import blkcpy_pkg::*;
#(
    parameter int RD_T  = 3,
    parameter int WR_T  = 3,
    parameter int GAP_T = 2,
    parameter int REP_T = 5,
    parameter int TW    = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          more_i,
    output phase_e        phase_o,
    output logic [TW-1:0] tstate_o,
    output logic          load_o,
    output logic          grab_o,
    output logic          step_o,
    output logic          done_o
);
    localparam logic [TW-1:0] RD_L  = TW'(RD_T - 1);
    localparam logic [TW-1:0] WR_L  = TW'(WR_T - 1);
    localparam logic [TW-1:0] GAP_L = TW'(GAP_T - 1);
    localparam logic [TW-1:0] REP_L = TW'(REP_T - 1);

    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] t;
        logic          done;
    } seq_s;

    seq_s s_d, s_q;
    logic [TW-1:0] lim;
    logic          last;

    always_comb begin
        case (s_q.ph)
            PH_RD:   lim = RD_L;
            PH_WR:   lim = WR_L;
            PH_GAP:  lim = GAP_L;
            PH_REP:  lim = REP_L;
            default: lim = '0;
        endcase
        last = (s_q.t == lim);

        s_d      = s_q;
        s_d.done = 1'b0;
        load_o   = 1'b0;
        grab_o   = 1'b0;
        step_o   = 1'b0;

        if (s_q.ph == PH_IDLE) begin
            if (start_i) begin
                load_o  = 1'b1;
                s_d.ph  = PH_RD;
                s_d.t   = '0;
            end
        end else if (last) begin
            s_d.t = '0;
            case (s_q.ph)
                PH_RD: begin
                    grab_o = 1'b1;
                    s_d.ph = PH_WR;
                end
                PH_WR:  s_d.ph = PH_GAP;
                PH_GAP: begin
                    step_o = 1'b1;
                    if (more_i) begin
                        s_d.ph = PH_REP;
                    end else begin
                        s_d.ph   = PH_IDLE;
                        s_d.done = 1'b1;
                    end
                end
                default: s_d.ph = PH_RD;
            endcase
        end else begin
            s_d.t = s_q.t + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{ph: PH_IDLE, t: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o  = s_q.ph;
    assign tstate_o = s_q.t;
    assign done_o   = s_q.done;
endmodule

// File: rtl/blkcpy_flags.sv
module blkcpy_flags
    import blkcpy_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] byte_i,
    input  logic [7:0]    flags_i,
    input  logic          more_i,
    output logic [7:0]    flags_o
);
    logic [DW-1:0] sum;

    always_comb begin
        sum              = acc_i + byte_i;
        flags_o          = flags_i;
        flags_o[FB_Y]    = sum[5];
        flags_o[FB_X]    = sum[3];
        flags_o[FB_HALF] = 1'b0;
        flags_o[FB_SUB]  = 1'b0;
        flags_o[FB_PV]   = more_i;
    end
endmodule

// File: rtl/blkcpy_regs.sv
module blkcpy_regs #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          grab_i,
    input  logic          step_i,
    input  logic [AW-1:0] src_init_i,
    input  logic [AW-1:0] dst_init_i,
    input  logic [AW-1:0] cnt_init_i,
    input  logic [DW-1:0] acc_init_i,
    input  logic [7:0]    flags_init_i,
    input  logic [DW-1:0] rdata_i,
    input  logic [7:0]    flags_step_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [AW-1:0] cnt_o,
    output logic [DW-1:0] byte_o,
    output logic [DW-1:0] acc_o,
    output logic [7:0]    flags_o,
    output logic          more_o
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] cnt;
        logic [DW-1:0] dat;
        logic [DW-1:0] acc;
        logic [7:0]    flg;
    } regs_s;

    regs_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.src = src_init_i;
            r_d.dst = dst_init_i;
            r_d.cnt = cnt_init_i;
            r_d.acc = acc_init_i;
            r_d.flg = flags_init_i;
        end
        if (grab_i) begin
            r_d.dat = rdata_i;
        end
        if (step_i) begin
            r_d.src = r_q.src + 1'b1;
            r_d.dst = r_q.dst + 1'b1;
            r_d.cnt = r_q.cnt - 1'b1;
            r_d.flg = flags_step_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_o   = r_q.src;
    assign dst_o   = r_q.dst;
    assign cnt_o   = r_q.cnt;
    assign byte_o  = r_q.dat;
    assign acc_o   = r_q.acc;
    assign flags_o = r_q.flg;
    // a count of 1 is the only one that reaches zero on this step
    assign more_o  = (r_q.cnt != AW'(1));
endmodule

// File: rtl/blkcpy_top.sv
module blkcpy_top
    import blkcpy_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int RD_T  = 3,
    parameter int WR_T  = 3,
    parameter int GAP_T = 2,
    parameter int REP_T = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [15:0]   src_init_i,
    input  logic [15:0]   dst_init_i,
    input  logic [15:0]   cnt_init_i,
    input  logic [7:0]    acc_i,
    input  logic [7:0]    flags_i,
    input  logic [7:0]    mem_rdata_i,
    output logic [15:0]   mem_addr_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [7:0]    mem_wdata_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [2:0]    mcyc_o,
    output logic [2:0]    tstate_o,
    output logic [15:0]   src_o,
    output logic [15:0]   dst_o,
    output logic [15:0]   cnt_o,
    output logic [7:0]    flags_o
);
    localparam int MAX_T = (RD_T > WR_T ? RD_T : WR_T) > (GAP_T > REP_T ? GAP_T : REP_T)
                         ? (RD_T > WR_T ? RD_T : WR_T) : (GAP_T > REP_T ? GAP_T : REP_T);
    localparam int TW    = (MAX_T > 1) ? $clog2(MAX_T) : 1;

    phase_e        phase;
    logic [TW-1:0] tst;
    logic          load, grab, step, more;
    logic [AW-1:0] src_q, dst_q, cnt_q;
    logic [DW-1:0] byte_q, acc_q;
    logic [7:0]    flg_q, flg_step;

    blkcpy_seq #(
        .RD_T (RD_T),
        .WR_T (WR_T),
        .GAP_T(GAP_T),
        .REP_T(REP_T),
        .TW   (TW)
    ) seq_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .more_i  (more),
        .phase_o (phase),
        .tstate_o(tst),
        .load_o  (load),
        .grab_o  (grab),
        .step_o  (step),
        .done_o  (done_o)
    );

    blkcpy_regs #(.AW(AW), .DW(DW)) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .grab_i      (grab),
        .step_i      (step),
        .src_init_i  (src_init_i[AW-1:0]),
        .dst_init_i  (dst_init_i[AW-1:0]),
        .cnt_init_i  (cnt_init_i[AW-1:0]),
        .acc_init_i  (acc_i[DW-1:0]),
        .flags_init_i(flags_i),
        .rdata_i     (mem_rdata_i[DW-1:0]),
        .flags_step_i(flg_step),
        .src_o       (src_q),
        .dst_o       (dst_q),
        .cnt_o       (cnt_q),
        .byte_o      (byte_q),
        .acc_o       (acc_q),
        .flags_o     (flg_q),
        .more_o      (more)
    );

    blkcpy_flags #(.DW(DW)) flags_i0 (
        .acc_i  (acc_q),
        .byte_i (byte_q),
        .flags_i(flg_q),
        .more_i (more),
        .flags_o(flg_step)
    );

    always_comb begin
        mem_addr_o = '0;
        if (phase == PH_RD) begin
            mem_addr_o = 16'(src_q);
        end else if (phase == PH_WR) begin
            mem_addr_o = 16'(dst_q);
        end
    end

    assign mem_rd_o    = (phase == PH_RD);
    assign mem_wr_o    = (phase == PH_WR);
    assign mem_wdata_o = 8'(byte_q);
    assign busy_o      = (phase != PH_IDLE);
    assign mcyc_o      = phase;
    assign tstate_o    = 3'(tst);
    assign src_o       = 16'(src_q);
    assign dst_o       = 16'(dst_q);
    assign cnt_o       = 16'(cnt_q);
    assign flags_o     = flg_q;
endmodule

// File: rtl/blkcpy_chk.sv
module blkcpy_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic [15:0] mem_addr_o,
    input logic [7:0]  mem_wdata_o,
    input logic        busy_o,
    input logic        done_o,
    input logic [7:0]  flags_o
);
    a_r3_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_o && mem_wr_o));

    a_r2_write_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_wr_o) |-> $past(mem_rd_o));

    a_r3_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_wr_o && $past(mem_wr_o)) |-> ($stable(mem_addr_o) && $stable(mem_wdata_o)));

    a_r6_end_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r6_pv_clear_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !flags_o[2]);

    a_r7_half_sub_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!flags_o[4] && !flags_o[1]));

    a_r7_szc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ($stable(flags_o[7:6]) && $stable(flags_o[0])));
endmodule

bind blkcpy_top blkcpy_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .flags_o    (flags_o)
);

// File: tb/blkcpy_top_tb_top.sv
module blkcpy_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] src_i = '0, dst_i = '0, cnt_i = '0;
    logic [7:0]  acc = '0, flg = '0;
    logic [7:0]  rdata;
    logic [15:0] addr;
    logic        rd, wr, busy, done;
    logic [7:0]  wdata, flags;
    logic [2:0]  mcyc, tst;
    logic [15:0] src_o, dst_o, cnt_o;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign rdata = pat(addr);

    blkcpy_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .src_init_i(src_i), .dst_init_i(dst_i), .cnt_init_i(cnt_i),
        .acc_i(acc), .flags_i(flg), .mem_rdata_i(rdata),
        .mem_addr_o(addr), .mem_rd_o(rd), .mem_wr_o(wr), .mem_wdata_o(wdata),
        .busy_o(busy), .done_o(done), .mcyc_o(mcyc), .tstate_o(tst),
        .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 strobes", {rd, wr}, 0);
        chk("R1 regs", {cnt_o, src_o, flags}, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after release", {busy, done, rd, wr}, 0);
    endtask

    task automatic t_copy(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n,
                          input logic [7:0] a, input logic [7:0] f, input bit poke);
        logic [7:0] sum, fe;
        src_i = s; dst_i = d; cnt_i = n; acc = a; flg = f;
        start = 1'b1;
        for (int i = 0; i < int'(n); i++) begin
            for (int k = 0; k < 3; k++) begin
                tick();
                start = 1'b0;
                chk("R2 read strobe", {rd, wr}, 2'b10);
                chk("R2 read addr", addr, 16'(s + i));
                chk("R2 tstate", tst, k);
            end
            for (int k = 0; k < 3; k++) begin
                tick();
                chk("R3 write strobe", {rd, wr}, 2'b01);
                chk("R3 write addr", addr, 16'(d + i));
                chk("R3 write data", wdata, pat(16'(s + i)));
            end
            for (int k = 0; k < 2; k++) begin
                tick();
                chk("R4 gap quiet", {busy, rd, wr}, 3'b100);
                if (poke && i == 0 && k == 0) begin
                    start = 1'b1; src_i = 16'hABCD; dst_i = 16'h1111; cnt_i = 16'h0009;
                end else begin
                    start = 1'b0;
                end
            end
            tick();
            sum = a + pat(16'(s + i));
            fe = {f[7], f[6], sum[5], 1'b0, sum[3], (i != int'(n) - 1), 1'b0, f[0]};
            chk("R4 src step", src_o, 16'(s + i + 1));
            chk("R4 dst step", dst_o, 16'(d + i + 1));
            chk("R4 count step", cnt_o, 16'(n - 16'(i) - 1));
            chk("R8 R7 flags", flags, fe);
            if (i == int'(n) - 1) begin
                chk("R6 done pulse", {done, busy}, 2'b10);
                tick();
                chk("R6 done one clock", {done, busy}, 2'b00);
            end else begin
                chk("R5 repeat penalty", {busy, rd, wr, tst}, {3'b100, 3'd0});
                for (int k = 1; k < 5; k++) begin
                    tick();
                    chk("R5 penalty quiet", {busy, rd, wr, tst}, {3'b100, 3'(k)});
                end
            end
        end
        if (poke) chk("R10 start ignored", src_o, 16'(s + n));
    endtask

    task automatic t_zero_count();
        src_i = 16'h0100; dst_i = 16'h0200; cnt_i = 16'h0000; acc = 8'h00; flg = 8'h00;
        start = 1'b1;
        tick();
        start = 1'b0;
        repeat (7) tick();
        tick();
        chk("R9 count wraps", cnt_o, 16'hFFFF);
        chk("R9 still repeating", {busy, flags[2]}, 2'b11);
        repeat (5) tick();
        chk("R9 second read", {rd, addr}, {1'b1, 16'h0101});
        t_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_copy(16'h1000, 16'h2000, 16'd3, 8'h00, 8'hC1, 1'b0);  // R5 R6 R7 R8
        t_copy(16'h0040, 16'h0080, 16'd1, 8'h2A, 8'h00, 1'b0);  // R6 single byte
        t_copy(16'hFFFE, 16'hFFFF, 16'd3, 8'hF7, 8'hFF, 1'b0);  // R11 pointer wrap
        t_copy(16'h3000, 16'h4000, 16'd2, 8'h55, 8'h40, 1'b1);  // R10
        t_zero_count();                                           // R9
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule